// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Data Cache

This block is a small data cache placed between a processor port and a main-memory port that moves whole blocks. Every processor word address is cut into three fields: a word offset in the lowest bits, a set index above it, and a tag in the remaining upper bits. Both ways of the indexed set are compared against the tag at the same time. A hit is answered in the cycle the request is presented. A miss stalls the processor while the controller chooses a victim, writes it back if it holds modified data, and fetches the missing block.

Writes are write-back with write-allocate. A write hit changes only the cached copy and marks the block dirty. A write miss first fetches the block and then completes as a write hit. Replacement is exact least-recently-used for two ways, kept as one recency flag per way. Empty ways are always filled before any valid block is replaced.

The controller is a three-state machine. IDLE performs the lookup. On a miss with a dirty victim it goes IDLE→EVICT, and on a miss with a clean or empty victim it goes IDLE→FILL. When memory acknowledges the write-back it goes EVICT→FILL. When memory acknowledges the fill it goes FILL→IDLE, and the held request then hits. The design assumes SETS and WORDS are powers of two, each at least 2.

Top module: `cache2w_top`

## Requirements
- R1: Address fields are fixed as follows. The word offset is cpu_addr[OFF_W-1:0], with OFF_W = log2(WORDS). The set index is the next log2(SETS) bits. The tag is all bits above the set index. Every memory transfer carries a block address equal to the word address shifted right by OFF_W. Each set keeps its contents separately from the other sets.
- R2: When cpu_req is high and the address hits, cpu_ready is high in the same cycle, cpu_rdata holds the addressed word for a read, and no memory request is raised.
- R3: When the address misses, cpu_ready stays low and a memory request starts in the next cycle. cpu_ready stays low while mem_req is high. After the fill, the held request completes with the data fetched from memory.
- R4: A write hit updates the cached word without any memory traffic, and a later read of that word returns the new value.
- R5: A write miss reads the block from memory with mem_we low, stores it, and then applies the write in the cache. A later read returns the written word.
- R6: The victim is way 0 if way 0 is invalid, otherwise way 1 if way 1 is invalid, otherwise the way whose recency flag is 0.
- R7: Each hit sets the recency flag of the way that hit and clears the flag of the other way in that set. The block used most recently is therefore never the one evicted.
- R8: A dirty victim is first written to memory (mem_we high, block address of the victim, the victim's words in mem_wdata with word i at bits [i*DATA_W +: DATA_W]). The refill read follows as the very next transfer. A clean victim causes no memory write. A fill clears the dirty flag.
- R9: mem_req stays high, and mem_addr and mem_we stay stable, until mem_ack is sampled high. Each ack completes exactly one block transfer.
- R10: Reset clears every valid, dirty and recency flag. After reset cpu_ready is high, mem_req is low, and any access misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access request, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid while cpu_ready on a read hit |
| cpu_ready | output | 1 | Access completes in this cycle; low while stalled |
| mem_req | output | 1 | Block transfer request |
| mem_we | output | 1 | 1 = write-back, 0 = refill read |
| mem_addr | output | ADDR_W-OFF_W | Block address |
| mem_wdata | output | WORDS*DATA_W | Victim block for write-back |
| mem_rdata | input | WORDS*DATA_W | Fetched block, valid with mem_ack |
| mem_ack | input | 1 | One-cycle transfer completion |

## Verification
The bench sends a conflict sequence of five blocks into one set, so each of the three victim rules is exercised in turn. A design that ignored invalid ways, or inverted the recency flag, would evict the block just touched, and the next hit would show up as a stall with an extra memory read. A dirty eviction is checked for its address, its data and its order before the refill. A design that refilled first, or that dropped the write, would return stale data when the evicted block is read back. A reset in the middle of the run must turn a resident block back into a miss, and a second set must keep its contents while its neighbour thrashes.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EVICT = 2'd1,
        ST_FILL  = 2'd2
    } cstate_e;

    // Victim choice: empty way 0, else empty way 1, else the way not used last.
    function automatic logic pick_victim(input logic [1:0] vld, input logic [1:0] recent);
        if (!vld[0]) return 1'b0;
        if (!vld[1]) return 1'b1;
        return recent[0] & ~recent[1];
    endfunction

endpackage

// File: rtl/cache2w_tags.sv
module cache2w_tags #(
    parameter int SETS  = 8,
    parameter int TAG_W = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(SETS)-1:0]  idx,
    input  logic [TAG_W-1:0]         tag,
    input  logic                     touch_en,
    input  logic                     touch_wr,
    input  logic                     fill_en,
    input  logic                     sel_way,
    output logic                     hit,
    output logic                     hit_way,
    output logic                     pick_way,
    output logic                     sel_dirty,
    output logic [TAG_W-1:0]         sel_tag
);
    import cache2w_pkg::*;

    logic [TAG_W-1:0] tag_q   [SETS][2];
    logic [1:0]       valid_q [SETS];
    logic [1:0]       dirty_q [SETS];
    logic [1:0]       use_q   [SETS];
    logic [1:0]       match;

    for (genvar w = 0; w < 2; w++) begin : g_way
        assign match[w] = valid_q[idx][w] && (tag_q[idx][w] == tag);
    end

    assign hit       = |match;
    assign hit_way   = match[1];
    assign pick_way  = pick_victim(valid_q[idx], use_q[idx]);
    assign sel_dirty = valid_q[idx][sel_way] && dirty_q[idx][sel_way];
    assign sel_tag   = tag_q[idx][sel_way];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= 2'b00;
                dirty_q[s] <= 2'b00;
                use_q[s]   <= 2'b00;
            end
        end else begin
            if (fill_en) begin
                valid_q[idx][sel_way] <= 1'b1;
                dirty_q[idx][sel_way] <= 1'b0;
            end
            if (touch_en) begin
                use_q[idx][hit_way]  <= 1'b1;
                use_q[idx][~hit_way] <= 1'b0;
                if (touch_wr) dirty_q[idx][hit_way] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) tag_q[idx][sel_way] <= tag;
    end

endmodule

// File: rtl/cache2w_data.sv
module cache2w_data #(
    parameter int SETS   = 8,
    parameter int WORDS  = 4,
    parameter int DATA_W = 32
) (
    input  logic                         clk,
    input  logic [$clog2(SETS)-1:0]      idx,
    input  logic [$clog2(WORDS)-1:0]     off,
    input  logic                         hit_way,
    input  logic                         wr_en,
    input  logic [DATA_W-1:0]            wdata,
    input  logic                         sel_way,
    input  logic                         fill_en,
    input  logic [WORDS*DATA_W-1:0]      fill_line,
    output logic [DATA_W-1:0]            rd_word,
    output logic [WORDS*DATA_W-1:0]      sel_line
);
    logic [DATA_W-1:0] word_q [SETS][2][WORDS];

    assign rd_word = word_q[idx][hit_way][off];

    for (genvar g = 0; g < WORDS; g++) begin : g_line
        assign sel_line[g*DATA_W +: DATA_W] = word_q[idx][sel_way][g];
    end

    always_ff @(posedge clk) begin
        if (wr_en) word_q[idx][hit_way][off] <= wdata;
        if (fill_en) begin
            for (int k = 0; k < WORDS; k++) begin
                word_q[idx][sel_way][k] <= fill_line[k*DATA_W +: DATA_W];
            end
        end
    end

endmodule

// File: rtl/cache2w_ctrl.sv
module cache2w_ctrl (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cpu_req,
    input  logic                   hit,
    input  logic                   pick_way,
    input  logic                   sel_dirty,
    input  logic                   mem_ack,
    output cache2w_pkg::cstate_e   state,
    output logic                   sel_way,
    output logic                   cpu_ready,
    output logic                   mem_req,
    output logic                   mem_we,
    output logic                   touch_en,
    output logic                   fill_en
);
    import cache2w_pkg::*;

    cstate_e state_q, state_d;
    logic    vic_q;
    logic    miss;

    assign state = state_q;
    assign miss  = (state_q == ST_IDLE) && cpu_req && !hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            vic_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (miss) vic_q <= pick_way;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (miss) state_d = sel_dirty ? ST_EVICT : ST_FILL;
            ST_EVICT: if (mem_ack) state_d = ST_FILL;
            ST_FILL:  if (mem_ack) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        cpu_ready = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        touch_en  = 1'b0;
        fill_en   = 1'b0;
        sel_way   = vic_q;
        unique case (state_q)
            ST_IDLE: begin
                sel_way   = pick_way;
                cpu_ready = !cpu_req || hit;
                touch_en  = cpu_req && hit;
            end
            ST_EVICT: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            ST_FILL: begin
                mem_req = 1'b1;
                fill_en = mem_ack;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/cache2w_top.sv
module cache2w_top #(
    parameter int SETS   = 8,
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 12
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  cpu_req,
    input  logic                                  cpu_we,
    input  logic [ADDR_W-1:0]                     cpu_addr,
    input  logic [DATA_W-1:0]                     cpu_wdata,
    output logic [DATA_W-1:0]                     cpu_rdata,
    output logic                                  cpu_ready,
    output logic                                  mem_req,
    output logic                                  mem_we,
    output logic [ADDR_W-$clog2(WORDS)-1:0]       mem_addr,
    output logic [WORDS*DATA_W-1:0]               mem_wdata,
    input  logic [WORDS*DATA_W-1:0]               mem_rdata,
    input  logic                                  mem_ack
);
    import cache2w_pkg::*;

    localparam int OFF_W = $clog2(WORDS);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

    logic [OFF_W-1:0] off;
    logic [IDX_W-1:0] idx;
    logic [TAG_W-1:0] tag;
    logic [TAG_W-1:0] sel_tag;
    logic             hit, hit_way, pick_way, sel_way, sel_dirty;
    logic             touch_en, fill_en;
    cstate_e          state;

    assign off = cpu_addr[OFF_W-1:0];
    assign idx = cpu_addr[OFF_W +: IDX_W];
    assign tag = cpu_addr[ADDR_W-1 -: TAG_W];

    assign mem_addr = mem_we ? {sel_tag, idx} : {tag, idx};

    cache2w_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_req   (cpu_req),
        .hit       (hit),
        .pick_way  (pick_way),
        .sel_dirty (sel_dirty),
        .mem_ack   (mem_ack),
        .state     (state),
        .sel_way   (sel_way),
        .cpu_ready (cpu_ready),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .touch_en  (touch_en),
        .fill_en   (fill_en)
    );

    cache2w_tags #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx       (idx),
        .tag       (tag),
        .touch_en  (touch_en),
        .touch_wr  (cpu_we),
        .fill_en   (fill_en),
        .sel_way   (sel_way),
        .hit       (hit),
        .hit_way   (hit_way),
        .pick_way  (pick_way),
        .sel_dirty (sel_dirty),
        .sel_tag   (sel_tag)
    );

    cache2w_data #(.SETS(SETS), .WORDS(WORDS), .DATA_W(DATA_W)) u_data (
        .clk       (clk),
        .idx       (idx),
        .off       (off),
        .hit_way   (hit_way),
        .wr_en     (touch_en && cpu_we),
        .wdata     (cpu_wdata),
        .sel_way   (sel_way),
        .fill_en   (fill_en),
        .fill_line (mem_rdata),
        .rd_word   (cpu_rdata),
        .sel_line  (mem_wdata)
    );

endmodule

// File: rtl/cache2w_chk.sv
module cache2w_chk #(
    parameter int BLK_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_req,
    input logic             cpu_ready,
    input logic             mem_req,
    input logic             mem_we,
    input logic             mem_ack,
    input logic [BLK_W-1:0] mem_addr
);
    AST_HIT_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req && cpu_ready |-> !mem_req);                                   // R2
    AST_STALL_DURING_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !cpu_ready);                                              // R3
    AST_MISS_STARTS_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req && !cpu_ready && !mem_req |=> mem_req);                       // R3
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req);                                     // R9
    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> $stable(mem_addr) && $stable(mem_we));        // R9
    AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && mem_ack |=> mem_req && !mem_we);                 // R8
endmodule

bind cache2w_top cache2w_chk #(.BLK_W(ADDR_W - $clog2(WORDS))) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_ready (cpu_ready),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr)
);

// File: tb/test_cache2w_top.sv
`timescale 1ns/1ps
module test_cache2w_top;
    localparam int SETS   = 4;
    localparam int WORDS  = 2;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 8;
    localparam int OFF_W  = 1;
    localparam int BLK_W  = ADDR_W - OFF_W;
    localparam int LINE_W = WORDS * DATA_W;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int LAT    = 2;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              rst_n, cpu_req, cpu_we, cpu_ready, mem_req, mem_we, mem_ack;
    logic [ADDR_W-1:0] cpu_addr;
    logic [DATA_W-1:0] cpu_wdata, cpu_rdata;
    logic [BLK_W-1:0]  mem_addr;
    logic [LINE_W-1:0] mem_wdata, mem_rdata;

    cache2w_top #(.SETS(SETS), .WORDS(WORDS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_cache2w_top (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    int checks = 0;
    int errors = 0;
    logic [DATA_W-1:0] backing [DEPTH];
    logic [DATA_W-1:0] gold    [DEPTH];
    int rd_count = 0;
    int wb_count = 0;
    int hs_err   = 0;
    logic [BLK_W-1:0]  last_rd_blk, last_wb_blk;
    logic [LINE_W-1:0] last_wb_line;
    bit                ops_q [$];
    logic [DATA_W-1:0] exp_q [$];
    logic [ADDR_W-1:0] expa_q [$];

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Memory responder: block transfer per request, ack after LAT cycles.
    initial begin
        mem_ack   = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (rst_n && mem_req) begin
                logic [BLK_W-1:0]  cap_a;
                logic              cap_we;
                logic [LINE_W-1:0] cap_d;
                cap_a = mem_addr; cap_we = mem_we; cap_d = mem_wdata;
                for (int i = 0; i < LAT; i++) begin
                    @(negedge clk);
                    if (!mem_req || mem_addr != cap_a || mem_we != cap_we) hs_err++;
                end
                if (cap_we) begin
                    for (int k = 0; k < WORDS; k++) backing[cap_a*WORDS + k] = cap_d[k*DATA_W +: DATA_W];
                    wb_count++; last_wb_blk = cap_a; last_wb_line = cap_d;
                end else begin
                    for (int k = 0; k < WORDS; k++) mem_rdata[k*DATA_W +: DATA_W] = backing[cap_a*WORDS + k];
                    rd_count++; last_rd_blk = cap_a;
                end
                ops_q.push_back(cap_we);
                mem_ack = 1'b1;
                @(negedge clk);
                mem_ack = 1'b0;
            end
        end
    end

    // Scoreboard monitor: pops expected read data when a read completes.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rst_n && cpu_req && cpu_ready && !cpu_we) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 unexpected read completion", int'(cpu_rdata), 0);
                end else begin
                    logic [DATA_W-1:0] e;
                    logic [ADDR_W-1:0] a;
                    e = exp_q.pop_front();
                    a = expa_q.pop_front();
                    check(cpu_rdata == e, $sformatf("R2/R3 read data at %0h", a), int'(cpu_rdata), int'(e));
                end
            end
        end
    end

    // Driver: one processor access, returns number of stall cycles.
    task automatic access(input bit we, input logic [ADDR_W-1:0] a,
                          input logic [DATA_W-1:0] d, output int stalls);
        cpu_we = we; cpu_addr = a; cpu_wdata = d;
        if (!we) begin
            exp_q.push_back(gold[a]);
            expa_q.push_back(a);
        end else begin
            gold[a] = d;
        end
        cpu_req = 1'b1;
        stalls = 0;
        #1;
        while (!cpu_ready) begin
            @(negedge clk);
            #1;
            stalls++;
        end
        @(negedge clk);
        cpu_req = 1'b0;
        cpu_we  = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired (R3 stall never ended)");
        summary();
        $finish;
    end

    initial begin
        int st, rd0, wb0;
        for (int i = 0; i < DEPTH; i++) begin
            backing[i] = 16'h4000 + 16'(i * 37);
            gold[i]    = backing[i];
        end
        rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(cpu_ready == 1'b1, "R10 ready after reset", int'(cpu_ready), 1);
        check(mem_req == 1'b0, "R10 no mem request after reset", int'(mem_req), 0);
        @(negedge clk);

        // Set 0 addresses: 0x10 (A), 0x18 (B), 0x20 (C), 0x28 (D), 0x30 (E)
        rd0 = rd_count;
        access(1'b0, 8'h10, '0, st);
        check(st > 0, "R10 first access misses", st, 1);
        check(rd_count == rd0 + 1, "R3 one refill on read miss", rd_count - rd0, 1);
        check(last_rd_blk == 7'h08, "R1 refill block address", int'(last_rd_blk), 8);

        rd0 = rd_count;
        access(1'b0, 8'h11, '0, st);
        check(st == 0, "R1 second word of block hits", st, 0);
        check(rd_count == rd0, "R2 hit makes no memory read", rd_count - rd0, 0);

        rd0 = rd_count; wb0 = wb_count;
        access(1'b1, 8'h10, 16'hBEEF, st);
        check(st == 0 && rd_count == rd0 && wb_count == wb0, "R4 write hit stays local", st, 0);
        access(1'b0, 8'h10, '0, st);
        check(st == 0, "R4 read after write hits", st, 0);

        rd0 = rd_count; wb0 = wb_count;
        access(1'b0, 8'h18, '0, st);
        check(rd_count == rd0 + 1 && wb_count == wb0, "R6 empty way filled, no write-back", wb_count - wb0, 0);
        access(1'b0, 8'h10, '0, st);
        check(st == 0, "R6 first block kept when empty way used", st, 0);

        wb0 = wb_count;
        access(1'b0, 8'h20, '0, st);
        check(wb_count == wb0, "R7 least recent clean block evicted", wb_count - wb0, 0);
        access(1'b0, 8'h10, '0, st);
        check(st == 0, "R7 most recent block survives eviction", st, 0);

        rd0 = rd_count; wb0 = wb_count;
        access(1'b1, 8'h28, 16'h1234, st);
        check(rd_count == rd0 + 1 && wb_count == wb0, "R5 write miss allocates by read", rd_count - rd0, 1);
        check(ops_q[ops_q.size()-1] == 1'b0, "R5 allocate transfer is a read", int'(ops_q[ops_q.size()-1]), 0);
        access(1'b0, 8'h28, '0, st);
        check(st == 0, "R5 written block now resident", st, 0);

        rd0 = rd_count; wb0 = wb_count;
        access(1'b0, 8'h30, '0, st);
        check(wb_count == wb0 + 1, "R8 dirty victim written back", wb_count - wb0, 1);
        check(last_wb_blk == 7'h08, "R8 write-back block address", int'(last_wb_blk), 8);
        check(last_wb_line[DATA_W-1:0] == 16'hBEEF, "R8 write-back data word 0", int'(last_wb_line[DATA_W-1:0]), 16'hBEEF);
        check(ops_q[ops_q.size()-2] == 1'b1 && ops_q[ops_q.size()-1] == 1'b0,
              "R8 write-back precedes refill", int'(ops_q[ops_q.size()-1]), 0);

        wb0 = wb_count;
        access(1'b0, 8'h10, '0, st);
        check(wb_count == wb0 + 1, "R8 second dirty eviction", wb_count - wb0, 1);

        rd0 = rd_count;
        access(1'b0, 8'h02, '0, st);
        check(rd_count == rd0 + 1 && last_rd_blk == 7'h01, "R1 other set refill address", int'(last_rd_blk), 1);
        access(1'b0, 8'h30, '0, st);
        check(st == 0, "R1 set 0 untouched by set 1 fill", st, 0);

        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd0 = rd_count;
        access(1'b0, 8'h30, '0, st);
        check(st > 0 && rd_count == rd0 + 1, "R10 resident block misses after reset", rd_count - rd0, 1);

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R2 all reads completed", exp_q.size(), 0);
        check(hs_err == 0, "R9 request held stable until ack", hs_err, 0);
        summary();
        $finish;
    end
endmodule